// File: doc/BRIEF.md
# Bus-Master IDE DMA Register Engine

This block is the register window and control sequencer of one bus-master IDE channel. Software programs a descriptor table pointer, optionally flags which of the two attached drives can do DMA, issues a command to the drive, and then sets the start bit. The engine fetches descriptors one after another over a simple request/acknowledge memory read port. Each descriptor names a buffer address and a byte count. For each descriptor the engine grants the drive's data requests one transfer at a time and advances the buffer address.

The run ends in one of two ways. It ends normally when the descriptor flagged as last is used up and the drive then raises its interrupt. It ends as a failure when the drive and the table disagree on the length. Software reads the status byte, clears the sticky bits by writing ones to them, and writes zero to the start bit. A clean run leaves the low three status bits at 100b.

Top module: `bmdma_engine`

## Requirements
- R1: After reset the control dword reads 0, the pointer reads 0, and mem_req, drv_dack and irq are low.
- R2: Writing 1 to command bit 0 while it holds 0 sets the active bit (status bit 0) on the next cycle. The engine then requests memory at the pointer value and holds mem_req and mem_addr steady until mem_ack.
- R3: A descriptor is two dwords. The dword at the descriptor address is the buffer address. The dword at address +4 holds the byte count in bits 15:0, where 0 means 65536, and the end-of-table flag in bit 31. The next descriptor follows at +8.
- R4: drv_dack is high only while the engine is active and has a loaded descriptor with bytes left, and drv_dreq is high. Each acknowledged cycle moves 2 bytes, and dat_addr advances by 2 after it. A drive request that arrives before start waits without loss.
- R5: When the last byte of the end-of-table descriptor moves, the active bit clears.
- R6: A drv_irq pulse sets status bit 2, and the irq output follows status bit 2.
- R7: Status bit 1 (error) is set in either of two cases: drv_irq arrives while the engine is still active, which also clears the active bit; or drv_dreq is high after the table is exhausted and before stop.
- R8: Writing 1 to status bits 1 or 2 clears them. Writing 0 leaves them unchanged.
- R9: Status bits 5 and 6 are read/write drive-capable flags. A transfer, a command write, or clearing bits 1 and 2 does not change them. Status bits 3, 4 and 7 read 0.
- R10: The pointer is a 32-bit register at offset 4 whose bits 1:0 read 0. A pointer write or a direction write while active is ignored.
- R11: Writing 0 to command bit 0 while it holds 1 clears the active bit on the next cycle and ends all memory and drive activity.
- R12: Command bit 3 is the direction and reads back as written. When it is 1, dat_write is 1, meaning data goes from the drive into memory.
- R13: A complete run with matching lengths ends with status bits 2:0 equal to 100b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte offset in the 8-byte window (bit 2 picks the dword) |
| reg_be | input | 4 | Byte enables of the written dword |
| reg_wdata | input | 32 | Write data; command in byte 0, status in byte 2 at offset 0 |
| reg_rdata | output | 32 | Read data of the dword picked by reg_addr |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor dword address |
| mem_ack | input | 1 | Read data valid, ends the request |
| mem_rdata | input | 32 | Descriptor dword |
| drv_dreq | input | 1 | Drive data request |
| drv_dack | output | 1 | Transfer grant; one 2-byte transfer per high cycle |
| drv_irq | input | 1 | Drive interrupt pulse |
| dat_addr | output | 32 | Buffer address of the current transfer |
| dat_write | output | 1 | Direction: 1 = write to memory |
| irq | output | 1 | Interrupt request to the host |

## Verification
Some properties are checked on every cycle: a held descriptor request keeps its address until acknowledged, a drive interrupt is always latched into the interrupt bit, the pointer never moves while active, a stop silences both ports on the next cycle, and no grant is given without the start bit. The bench scenarios show the rest. These are the descriptor walk and its address order, the 64 KiB encoding of a zero count, the two length-mismatch failures, requests that arrive before start, writes ignored while active, and the final status pattern software relies on.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int REG_W = 32;

    // command byte bit positions
    localparam int CMD_RUN_BIT = 0;
    localparam int CMD_DIR_BIT = 3;

    // status byte lanes within dword 0
    localparam int STAT_LANE = 2;
    localparam int CMD_LANE  = 0;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_GET_ADDR,
        SEQ_GET_LEN,
        SEQ_MOVE,
        SEQ_SPENT
    } seq_state_t;

    typedef struct packed {
        logic       rsv7;
        logic [1:0] cap;
        logic [1:0] rsv43;
        logic       intr;
        logic       err;
        logic       act;
    } stat_t;

    function automatic logic [7:0] cmd_byte(input logic run, input logic dir);
        cmd_byte = 8'h00;
        cmd_byte[CMD_RUN_BIT] = run;
        cmd_byte[CMD_DIR_BIT] = dir;
    endfunction

    function automatic logic is_running(input seq_state_t s);
        is_running = (s == SEQ_GET_ADDR) || (s == SEQ_GET_LEN) || (s == SEQ_MOVE);
    endfunction

endpackage

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [3:0]       reg_be,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             active,
    input  logic             set_err,
    input  logic             drv_irq,
    output logic             start_pulse,
    output logic             stop_pulse,
    output logic             cmd_start,
    output logic             cmd_dir,
    output logic [REG_W-1:0] tbl_ptr,
    output logic             irq
);

    localparam int LANES = REG_W / 8;

    logic  sel_ctl, sel_ptr, wr_cmd, wr_stat;
    logic  w_run, w_dir;
    logic  err_q, intr_q;
    logic [1:0] cap_q;
    logic [7:0] stat_wr;
    stat_t stat_view;

    assign sel_ctl = (reg_addr[2] == 1'b0);
    assign sel_ptr = (reg_addr[2] == 1'b1);
    assign wr_cmd  = reg_wr && sel_ctl && reg_be[CMD_LANE];
    assign wr_stat = reg_wr && sel_ctl && reg_be[STAT_LANE];
    assign w_run   = reg_wdata[8*CMD_LANE + CMD_RUN_BIT];
    assign w_dir   = reg_wdata[8*CMD_LANE + CMD_DIR_BIT];
    assign stat_wr = reg_wdata[8*STAT_LANE +: 8];

    assign start_pulse = wr_cmd &&  w_run && !cmd_start;
    assign stop_pulse  = wr_cmd && !w_run &&  cmd_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_start <= 1'b0;
            cmd_dir   <= 1'b0;
        end else if (wr_cmd) begin
            cmd_start <= w_run;
            if (!active)
                cmd_dir <= w_dir;
        end
    end

    // sticky status bits: hardware set has priority over a write-one clear
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q  <= 1'b0;
            intr_q <= 1'b0;
            cap_q  <= 2'b00;
        end else begin
            if (set_err)
                err_q <= 1'b1;
            else if (wr_stat && stat_wr[1])
                err_q <= 1'b0;
            if (drv_irq)
                intr_q <= 1'b1;
            else if (wr_stat && stat_wr[2])
                intr_q <= 1'b0;
            if (wr_stat)
                cap_q <= stat_wr[6:5];
        end
    end

    // pointer: one register per byte lane, frozen while active
    for (genvar b = 0; b < LANES; b++) begin : g_ptr
        logic [7:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst)
                lane_q <= 8'h00;
            else if (reg_wr && sel_ptr && reg_be[b] && !active)
                lane_q <= reg_wdata[8*b +: 8];
        end
        if (b == 0) begin : g_low
            assign tbl_ptr[7:0] = {lane_q[7:2], 2'b00};
        end else begin : g_hi
            assign tbl_ptr[8*b +: 8] = lane_q;
        end
    end

    always_comb begin
        stat_view       = '0;
        stat_view.act   = active;
        stat_view.err   = err_q;
        stat_view.intr  = intr_q;
        stat_view.cap   = cap_q;
    end

    always_comb begin
        reg_rdata = '0;
        if (sel_ptr) begin
            reg_rdata = tbl_ptr;
        end else begin
            reg_rdata[8*CMD_LANE +: 8]  = cmd_byte(cmd_start, cmd_dir);
            reg_rdata[8*STAT_LANE +: 8] = stat_view;
        end
    end

    assign irq = intr_q;

endmodule

// File: rtl/bmdma_seq.sv
module bmdma_seq
    import bmdma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int XFER_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_pulse,
    input  logic              stop_pulse,
    input  logic [ADDR_W-1:0] tbl_base,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata,
    input  logic              drv_dreq,
    output logic              drv_dack,
    input  logic              drv_irq,
    output logic [ADDR_W-1:0] dat_addr,
    output logic              active,
    output logic              set_err
);

    localparam int REM_W      = LEN_W + 1;
    localparam int DESC_BYTES = 8;
    localparam int LEN_OFS    = 4;
    localparam logic [REM_W-1:0]  STEP    = REM_W'(XFER_BYTES);
    localparam logic [REM_W-1:0]  FULL    = REM_W'(1) << LEN_W;
    localparam logic [ADDR_W-1:0] A_STEP  = ADDR_W'(XFER_BYTES);
    localparam logic [ADDR_W-1:0] A_DESC  = ADDR_W'(DESC_BYTES);
    localparam logic [ADDR_W-1:0] A_LENO  = ADDR_W'(LEN_OFS);

    seq_state_t        state_q;
    logic [ADDR_W-1:0] desc_ptr_q;
    logic [ADDR_W-1:0] buf_q;
    logic [REM_W-1:0]  remain_q;
    logic              last_q;
    logic [LEN_W-1:0]  len_field;
    logic              run_now;
    logic              final_beat;

    assign run_now    = is_running(state_q);
    assign len_field  = mem_rdata[LEN_W-1:0];
    assign final_beat = (remain_q <= STEP);

    assign active   = run_now;
    assign mem_req  = (state_q == SEQ_GET_ADDR) || (state_q == SEQ_GET_LEN);
    assign mem_addr = (state_q == SEQ_GET_LEN) ? desc_ptr_q + A_LENO : desc_ptr_q;
    assign drv_dack = (state_q == SEQ_MOVE) && drv_dreq;
    assign dat_addr = buf_q;
    assign set_err  = (run_now && drv_irq) || ((state_q == SEQ_SPENT) && drv_dreq);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SEQ_IDLE;
            desc_ptr_q <= '0;
            buf_q      <= '0;
            remain_q   <= '0;
            last_q     <= 1'b0;
        end else if (stop_pulse) begin
            state_q <= SEQ_IDLE;
        end else if (start_pulse) begin
            state_q    <= SEQ_GET_ADDR;
            desc_ptr_q <= tbl_base;
        end else if (run_now && drv_irq) begin
            state_q <= SEQ_SPENT;
        end else begin
            unique case (state_q)
                SEQ_GET_ADDR: if (mem_ack) begin
                    buf_q   <= mem_rdata;
                    state_q <= SEQ_GET_LEN;
                end
                SEQ_GET_LEN: if (mem_ack) begin
                    remain_q   <= (len_field == '0) ? FULL : REM_W'(len_field);
                    last_q     <= mem_rdata[ADDR_W-1];
                    desc_ptr_q <= desc_ptr_q + A_DESC;
                    state_q    <= SEQ_MOVE;
                end
                SEQ_MOVE: if (drv_dreq) begin
                    buf_q    <= buf_q + A_STEP;
                    remain_q <= remain_q - STEP;
                    if (final_beat)
                        state_q <= last_q ? SEQ_SPENT : SEQ_GET_ADDR;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine
    import bmdma_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int XFER_BYTES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [3:0]  reg_be,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    input  logic        drv_dreq,
    output logic        drv_dack,
    input  logic        drv_irq,
    output logic [31:0] dat_addr,
    output logic        dat_write,
    output logic        irq
);

    logic        st_active;
    logic        seq_err;
    logic        start_pulse;
    logic        stop_pulse;
    logic        cmd_start;
    logic        cmd_dir;
    logic [31:0] tbl_ptr;

    bmdma_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_be      (reg_be),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .active      (st_active),
        .set_err     (seq_err),
        .drv_irq     (drv_irq),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse),
        .cmd_start   (cmd_start),
        .cmd_dir     (cmd_dir),
        .tbl_ptr     (tbl_ptr),
        .irq         (irq)
    );

    bmdma_seq #(
        .ADDR_W     (REG_W),
        .LEN_W      (LEN_W),
        .XFER_BYTES (XFER_BYTES)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse),
        .tbl_base    (tbl_ptr),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .drv_dreq    (drv_dreq),
        .drv_dack    (drv_dack),
        .drv_irq     (drv_irq),
        .dat_addr    (dat_addr),
        .active      (st_active),
        .set_err     (seq_err)
    );

    assign dat_write = cmd_dir;

endmodule

// File: rtl/bmdma_engine_chk.sv
module bmdma_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic        drv_dack,
    input logic        drv_irq,
    input logic        irq,
    input logic        active,
    input logic [31:0] ptr,
    input logic        stop_pulse,
    input logic        cmd_start
);

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !stop_pulse && !drv_irq) |=> (mem_req && $stable(mem_addr)));

    assert_irq_latched_R6: assert property (@(posedge clk) disable iff (rst)
        drv_irq |=> irq);

    assert_ptr_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        active |=> $stable(ptr));

    assert_stop_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        stop_pulse |=> (!active && !mem_req && !drv_dack));

    assert_grant_needs_run_R4: assert property (@(posedge clk) disable iff (rst)
        drv_dack |-> cmd_start);

endmodule

bind bmdma_engine bmdma_engine_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .drv_dack   (drv_dack),
    .drv_irq    (drv_irq),
    .irq        (irq),
    .active     (st_active),
    .ptr        (tbl_ptr),
    .stop_pulse (stop_pulse),
    .cmd_start  (cmd_start)
);

// File: tb/tb_bmdma_engine.sv
`timescale 1ns/1ps
module tb_bmdma_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [3:0]  reg_be = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        drv_dreq;
    logic        drv_dack;
    logic        drv_irq;
    logic [31:0] dat_addr;
    logic        dat_write;
    logic        irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem_arr [64];
    int  drv_words;
    int  drv_load_val = 0;
    logic drv_load = 1'b0;
    logic irq_en = 1'b0;
    int  dack_cnt;
    logic [31:0] dack_log [16];

    always #2.5 clk = ~clk;

    bmdma_engine dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .drv_dreq(drv_dreq), .drv_dack(drv_dack),
        .drv_irq(drv_irq), .dat_addr(dat_addr), .dat_write(dat_write), .irq(irq)
    );

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (rst) mem_ack <= 1'b0;
        else     mem_ack <= mem_req && !mem_ack;
        mem_rdata <= mem_arr[mem_addr[7:2]];
    end

    // drive model: requests while words remain, interrupt after the last one
    assign drv_dreq = (drv_words != 0);
    always @(posedge clk) begin
        if (rst) begin
            drv_words <= 0;
            drv_irq   <= 1'b0;
        end else begin
            drv_irq <= irq_en && drv_dack && (drv_words == 1);
            if (drv_load)      drv_words <= drv_load_val;
            else if (drv_dack) drv_words <= drv_words - 1;
        end
    end

    // grant monitor
    always @(posedge clk) begin
        if (rst) dack_cnt <= 0;
        else if (drv_dack) begin
            dack_log[dack_cnt % 16] <= dat_addr;
            dack_cnt <= dack_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 4'h0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wr_cmd(input logic [7:0] v);   wr(3'd0, 4'b0001, {24'h0, v}); endtask
    task automatic wr_stat(input logic [7:0] v);  wr(3'd0, 4'b0100, {8'h0, v, 16'h0}); endtask

    task automatic stat_byte(output logic [7:0] s);
        logic [31:0] d;
        rd(3'd0, d);
        s = d[23:16];
    endtask

    task automatic drv_set(input int n);
        @(negedge clk);
        drv_load_val = n; drv_load = 1'b1;
        @(negedge clk);
        drv_load = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk);
            stat_byte(s);
            if (!s[0]) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic cleanup();
        drv_set(0);
        irq_en = 1'b0;
        wr_cmd(8'h08);
        wr_stat(8'h66);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(3'd0, d); check("R1 ctl dword", d, 32'h0);
        rd(3'd4, d); check("R1 pointer", d, 32'h0);
        check("R1 outputs", {29'h0, mem_req, drv_dack, irq}, 32'h0);
    endtask

    task automatic t_caps_ptr();
        logic [7:0] s;
        logic [31:0] d;
        wr_stat(8'hFF);
        stat_byte(s); check("R9 caps set, reserved zero", {24'h0, s}, 32'h60);
        wr_cmd(8'h08);
        stat_byte(s); check("R9 caps kept over cmd write", {24'h0, s}, 32'h60);
        rd(3'd0, d); check("R12 dir readback", {24'h0, d[7:0]}, 32'h08);
        check("R12 dat_write", {31'h0, dat_write}, 32'h1);
        wr(3'd4, 4'hF, 32'hFFFF_FFFF);
        rd(3'd4, d); check("R10 pointer low bits", d, 32'hFFFF_FFFC);
        wr(3'd4, 4'hF, 32'h0000_0040);
    endtask

    task automatic t_normal();
        logic [7:0] s;
        int base;
        mem_arr[16] = 32'h0000_1000; mem_arr[17] = 32'h0000_0004;
        mem_arr[18] = 32'h0000_2000; mem_arr[19] = 32'h8000_0006;
        base = dack_cnt;
        irq_en = 1'b1;
        drv_set(5);                          // request before start (R4)
        wr_cmd(8'h09);
        stat_byte(s); check("R2 active after start", {31'h0, s[0]}, 32'h1);
        check("R2 first fetch address", mem_addr, 32'h40);
        check("R2 request raised", {31'h0, mem_req}, 32'h1);
        wait_idle();
        check("R4 grant count", dack_cnt - base, 5);
        check("R3 addr0", dack_log[(base+0)%16], 32'h1000);
        check("R3 addr1", dack_log[(base+1)%16], 32'h1002);
        check("R3 addr2 next descriptor", dack_log[(base+2)%16], 32'h2000);
        check("R4 addr4", dack_log[(base+4)%16], 32'h2004);
        stat_byte(s); check("R13 R5 R6 status", {24'h0, s}, 32'h64);
        check("R6 irq out", {31'h0, irq}, 32'h1);
        wr_stat(8'h60);
        stat_byte(s); check("R8 zero writes keep bits", {24'h0, s}, 32'h64);
        wr_stat(8'h66);
        stat_byte(s); check("R8 W1C clears, R9 caps kept", {24'h0, s}, 32'h60);
        check("R8 irq low", {31'h0, irq}, 32'h0);
        cleanup();
    endtask

    task automatic t_late();
        logic [7:0] s;
        int base;
        mem_arr[16] = 32'h0000_3000; mem_arr[17] = 32'h8000_0004;
        base = dack_cnt;
        irq_en = 1'b1;
        wr_cmd(8'h09);
        repeat (10) @(negedge clk);
        check("R4 no grant without request", dack_cnt - base, 0);
        stat_byte(s); check("R4 still active waiting", {31'h0, s[0]}, 32'h1);
        drv_set(2);
        wait_idle();
        check("R4 late request grants", dack_cnt - base, 2);
        stat_byte(s); check("R13 late status", {29'h0, s[2:0]}, 32'h4);
        cleanup();
    endtask

    task automatic t_64k();
        logic [7:0] s;
        int base;
        mem_arr[16] = 32'h0001_0000; mem_arr[17] = 32'h8000_0000;
        base = dack_cnt;
        irq_en = 1'b1;
        drv_set(32768);
        wr_cmd(8'h09);
        wait_idle();
        check("R3 zero count is 64KiB", dack_cnt - base, 32768);
        check("R3 final address", dack_log[(dack_cnt-1)%16], 32'h0001_FFFE);
        stat_byte(s); check("R13 64KiB status", {29'h0, s[2:0]}, 32'h4);
        cleanup();
    endtask

    task automatic t_short_drive();
        logic [7:0] s;
        int base;
        mem_arr[16] = 32'h0000_4000; mem_arr[17] = 32'h8000_0008;
        base = dack_cnt;
        irq_en = 1'b1;
        drv_set(2);
        wr_cmd(8'h09);
        wait_idle();
        check("R7 grants before early end", dack_cnt - base, 2);
        stat_byte(s); check("R7 early drive end status", {29'h0, s[2:0]}, 32'h6);
        cleanup();
    endtask

    task automatic t_long_drive();
        logic [7:0] s;
        int base;
        mem_arr[16] = 32'h0000_5000; mem_arr[17] = 32'h8000_0004;
        base = dack_cnt;
        irq_en = 1'b1;
        drv_set(4);
        wr_cmd(8'h09);
        wait_idle();
        check("R7 grants stop at table end", dack_cnt - base, 2);
        stat_byte(s); check("R7 table end with request", {29'h0, s[2:0]}, 32'h2);
        cleanup();
    endtask

    task automatic t_stop_ignore();
        logic [7:0] s;
        logic [31:0] d;
        int base;
        mem_arr[16] = 32'h0000_6000; mem_arr[17] = 32'h8000_0004;
        base = dack_cnt;
        wr_cmd(8'h09);
        repeat (5) @(negedge clk);
        wr(3'd4, 4'hF, 32'h0000_0080);
        rd(3'd4, d); check("R10 pointer write ignored while active", d, 32'h40);
        wr_cmd(8'h01);
        rd(3'd0, d); check("R10 direction write ignored while active", {24'h0, d[7:0]}, 32'h09);
        wr_cmd(8'h08);
        stat_byte(s); check("R11 stop clears active", {29'h0, s[2:0]}, 32'h0);
        drv_set(2);
        repeat (5) @(negedge clk);
        check("R11 no grants after stop", dack_cnt - base, 0);
        check("R11 no memory request", {31'h0, mem_req}, 32'h0);
        cleanup();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_caps_ptr();
        t_normal();
        t_late();
        t_64k();
        t_short_drive();
        t_long_drive();
        t_stop_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule